// File: doc/BRIEF.md
# Four-Stage Lockable Watchdog

The block is a watchdog timer that counts ticks of a slow timebase through four chained stages. Every stage owns a 32-bit timeout and an expiry action. When a stage runs out, its action fires and counting restarts in the following stage. Software keeps the watchdog quiet by feeding it, which sends it back to stage 0 with an empty count. The actions are an interrupt level, a CPU reset pulse, a system reset pulse and a full reset pulse. The reset pulses are stretched to a programmed length in fast-clock cycles.

Software reaches the block through a flat write/address/data port and a combinational read-back. Every write except a write to the key register is dropped unless the key register holds the unlock value. This covers configuration, timeouts, feed, disable and interrupt clear. The block runs from the fast clock `clk_i`. The slow timebase arrives as the single-cycle enable `tick_i`.

Top module: `wdt_multistage`

## Requirements
- R1: After reset the block is locked (status bit 0 = 1), all stage actions are off, it is not running, it sits in stage 0, and `irq_o`, `cpu_rst_o`, `sys_rst_o` and `full_rst_o` are low.
- R2: Address map: 0 = key, 1 = config, 2 = control, 3 = status, 4..7 = timeouts of stages 0..3. Writes to the key register are always taken. All other writes are ignored unless the key register equals the `KEY` parameter. Status bit 0 reads 1 whenever the key register differs from `KEY`.
- R3: A stage expires on the tick that brings its count to its timeout, where a timeout of 0 acts as 1, and the sequencer then moves to the next stage. After stage 3 expires, the block stays in stage 3 and fires nothing more until it is fed or stops running. Status bits [5:4] give the stage.
- R4: Config fields [2:0], [5:3], [8:6] and [11:9] select the actions of stages 0..3. The codes are: 0 = none, 1 = interrupt, 2 = CPU reset, 3 = system reset, 4 = full reset. Codes 5..7 behave as 0.
- R5: An interrupt action sets `irq_o` (status bit 2). It stays high until a write with status bit 2 set clears it.
- R6: Config [14:12] sets the CPU pulse length and config [17:15] sets the length of the system and full pulses. Codes 0..7 give 100, 200, 300, 400, 500, 800, 1600 and 3200 ns. With the 12.5 ns clock these are 8, 16, 24, 32, 40, 64, 128 and 256 cycles.
- R7: Writing control bit 31 feeds the watchdog: it returns to stage 0 with a zero count. The control register always reads 0.
- R8: The block runs while config bit 31 (enable) or config bit 29 (boot enable) is set, and status bit 1 shows this. While it is not running it holds stage 0 with a zero count.
- R9: Writing control bit 0 disables the block. This sets all four actions to 0 and clears config bits 31 and 29.
- R10: While config bit 30 (pause) is set and `sleep_i` is high, the count and the stage hold. Without the pause bit, `sleep_i` has no effect.
- R11: Counting advances only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow timebase tick, one fast cycle wide |
| sleep_i | input | 1 | Sleep indication |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt level |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |
| full_rst_o | output | 1 | Full reset pulse |

## Verification
The bench runs random trials in which all four timeouts, all four actions (including the invalid codes) and both pulse lengths are drawn together. It then steps one tick short of each expiry and across it. This separates the stage sequencing from the action decode, and it separates the CPU-length selector from the system-length selector. Directed cases cover the rest:
- A feed in mid-stage, to show that the count restarts rather than just the stage.
- Sleep with and without the pause bit.
- Boot enable alone.
- Locked and wrong-key writes to each guarded register.
- Long idle periods without ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_IRQ  = 3'd1,
    ACT_CPU  = 3'd2,
    ACT_SYS  = 3'd3,
    ACT_FULL = 3'd4
  } wdt_act_e;

  localparam logic [2:0] A_KEY  = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;

  function automatic int len_ns(input logic [2:0] code);
    case (code)
      3'd0: return 100;
      3'd1: return 200;
      3'd2: return 300;
      3'd3: return 400;
      3'd4: return 500;
      3'd5: return 800;
      3'd6: return 1600;
      default: return 3200;
    endcase
  endfunction

  // ceil(ns / period), period in ps
  function automatic int len_cycles(input logic [2:0] code, input int clk_ps);
    return (len_ns(code) * 1000 + clk_ps - 1) / clk_ps;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter logic [31:0] KEY = 32'hA5C3_0F96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [1:0]       stage_i,
  input  logic             irq_i,
  output logic [3:0][2:0]  act_o,
  output logic [2:0]       cpu_len_o,
  output logic [2:0]       sys_len_o,
  output logic             run_o,
  output logic             pause_o,
  output logic [3:0][31:0] tmo_o,
  output logic             feed_o,
  output logic             irq_clr_o
);
  logic [31:0]      key_q;
  logic [3:0][2:0]  act_q;
  logic [2:0]       cpu_len_q, sys_len_q;
  logic             en_q, boot_q, pause_q;
  logic [3:0][31:0] tmo_q;
  logic             unlocked, wr_ok, dis_w;

  assign unlocked  = (key_q == KEY);
  assign wr_ok     = wr_en_i && unlocked;
  assign feed_o    = wr_ok && addr_i == A_CTRL && wdata_i[31];
  assign dis_w     = wr_ok && addr_i == A_CTRL && wdata_i[0];
  assign irq_clr_o = wr_ok && addr_i == A_STAT && wdata_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q     <= '0;
      act_q     <= '0;
      cpu_len_q <= '0;
      sys_len_q <= '0;
      en_q      <= 1'b0;
      boot_q    <= 1'b0;
      pause_q   <= 1'b0;
      tmo_q     <= '0;
    end else begin
      if (wr_en_i && addr_i == A_KEY) key_q <= wdata_i;
      if (wr_ok && addr_i == A_CFG) begin
        act_q     <= wdata_i[11:0];
        cpu_len_q <= wdata_i[14:12];
        sys_len_q <= wdata_i[17:15];
        boot_q    <= wdata_i[29];
        pause_q   <= wdata_i[30];
        en_q      <= wdata_i[31];
      end
      if (dis_w) begin
        act_q  <= '0;
        en_q   <= 1'b0;
        boot_q <= 1'b0;
      end
      if (wr_ok && addr_i[2]) tmo_q[addr_i[1:0]] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_KEY:   rdata_o = key_q;
      A_CFG:   rdata_o = {en_q, pause_q, boot_q, 11'b0, sys_len_q, cpu_len_q, act_q};
      A_STAT:  rdata_o = {26'b0, stage_i, 1'b0, irq_i, run_o, !unlocked};
      A_CTRL:  rdata_o = '0;
      default: rdata_o = tmo_q[addr_i[1:0]];
    endcase
  end

  assign act_o     = act_q;
  assign cpu_len_o = cpu_len_q;
  assign sys_len_o = sys_len_q;
  assign run_o     = en_q || boot_q;
  assign pause_o   = pause_q;
  assign tmo_o     = tmo_q;

  // R2
  locked_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !unlocked && addr_i != A_KEY) |=>
      ($stable(act_q) && $stable(en_q) && $stable(boot_q) && $stable(tmo_q)));
  // R9
  disable_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_w |=> (act_q == '0 && !en_q && !boot_q));
endmodule

// File: rtl/wdt_core.sv
module wdt_core import wdt_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             run_i,
  input  logic             feed_i,
  input  logic             irq_clr_i,
  input  logic [3:0][2:0]  act_i,
  input  logic [3:0][31:0] tmo_i,
  output logic [1:0]       stage_o,
  output logic             fire_o,
  output logic [2:0]       fire_act_o,
  output logic             irq_o
);
  logic [31:0] cnt_q;
  logic [1:0]  stage_q;
  logic        done_q, fire_q, irq_q;
  logic [2:0]  fire_act_q;
  logic        hit;

  assign hit = ({1'b0, cnt_q} + 33'd1) >= {1'b0, tmo_i[stage_q]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      stage_q    <= '0;
      done_q     <= 1'b0;
      fire_q     <= 1'b0;
      fire_act_q <= ACT_NONE;
      irq_q      <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (irq_clr_i) irq_q <= 1'b0;
      if (fire_q && fire_act_q == ACT_IRQ) irq_q <= 1'b1;
      if (!run_i || feed_i) begin
        cnt_q   <= '0;
        stage_q <= '0;
        done_q  <= 1'b0;
      end else if (tick_i && !hold_i && !done_q) begin
        if (hit) begin
          cnt_q      <= '0;
          fire_q     <= 1'b1;
          fire_act_q <= act_i[stage_q];
          if (stage_q == 2'd3) done_q <= 1'b1;
          else stage_q <= stage_q + 2'd1;
        end else begin
          cnt_q <= cnt_q + 32'd1;
        end
      end
    end
  end

  assign stage_o    = stage_q;
  assign fire_o     = fire_q;
  assign fire_act_o = fire_act_q;
  assign irq_o      = irq_q;

  // R3
  stage_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !feed_i) |=> (stage_q == $past(stage_q) || stage_q == $past(stage_q) + 2'd1));
  // R7
  feed_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_i |=> (stage_q == 2'd0 && cnt_q == 32'd0));
  // R10
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hold_i && !feed_i) |=> ($stable(cnt_q) && $stable(stage_q)));
  // R11
  fire_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> $past(tick_i));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse import wdt_pkg::*; #(
  parameter int CLK_PS = 12500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic [2:0] len_i,
  output logic       pulse_o
);
  localparam int W = $clog2(len_cycles(3'd7, CLK_PS) + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= W'(len_cycles(len_i, CLK_PS));
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  // R6
  pulse_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/wdt_multistage.sv
module wdt_multistage import wdt_pkg::*; #(
  parameter logic [31:0] KEY    = 32'hA5C3_0F96,
  parameter int          CLK_PS = 12500
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        sleep_i,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        cpu_rst_o,
  output logic        sys_rst_o,
  output logic        full_rst_o
);
  logic [3:0][2:0]  act;
  logic [3:0][31:0] tmo;
  logic [2:0]       cpu_len, sys_len, fire_act;
  logic [1:0]       stage;
  logic             run, pause, feed, irq_clr, fire, irq;
  logic [2:0]       pulses;

  wdt_regs #(.KEY(KEY)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .stage_i(stage), .irq_i(irq), .act_o(act), .cpu_len_o(cpu_len),
    .sys_len_o(sys_len), .run_o(run), .pause_o(pause), .tmo_o(tmo),
    .feed_o(feed), .irq_clr_o(irq_clr)
  );

  wdt_core u_core (
    .clk_i, .rst_ni, .tick_i, .hold_i(pause && sleep_i), .run_i(run),
    .feed_i(feed), .irq_clr_i(irq_clr), .act_i(act), .tmo_i(tmo),
    .stage_o(stage), .fire_o(fire), .fire_act_o(fire_act), .irq_o(irq)
  );

  // 0: CPU, 1: system, 2: full; system and full share the system length
  for (genvar g = 0; g < 3; g++) begin : g_pulse
    localparam logic [2:0] CODE = 3'(ACT_CPU) + 3'(g);
    wdt_pulse #(.CLK_PS(CLK_PS)) u_pulse (
      .clk_i, .rst_ni,
      .trig_i (fire && fire_act == CODE),
      .len_i  ((g == 0) ? cpu_len : sys_len),
      .pulse_o(pulses[g])
    );
  end

  assign {full_rst_o, sys_rst_o, cpu_rst_o} = pulses;
  assign irq_o = irq;
endmodule

// File: tb/wdt_multistage_bench.sv
module wdt_multistage_bench;
  localparam logic [31:0] KEY = 32'hA5C3_0F96;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sleep = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, cpu_rst, sys_rst, full_rst;
  int n_tests = 0, n_fail = 0;
  int run_w[3], last_w[3], n_p[3];

  always #5 clk = ~clk;

  wdt_multistage #(.KEY(KEY), .CLK_PS(12500)) u_wdt_multistage (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sleep_i(sleep),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst), .full_rst_o(full_rst)
  );

  always @(negedge clk) begin
    logic [2:0] o;
    o = {full_rst, sys_rst, cpu_rst};
    for (int k = 0; k < 3; k++) begin
      if (o[k]) run_w[k]++;
      else if (run_w[k] != 0) begin
        last_w[k] = run_w[k]; n_p[k]++; run_w[k] = 0;
      end
    end
  end

  function automatic int exp_len(input logic [2:0] c);
    int ns[8] = '{100, 200, 300, 400, 500, 800, 1600, 3200};
    return (ns[c] * 1000 + 12499) / 12500;
  endfunction

  function automatic logic [31:0] mk_cfg(input logic en, pau, boot,
      input logic [2:0] cl, sl, a0, a1, a2, a3);
    return {en, pau, boot, 11'b0, sl, cl, a3, a2, a1, a0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stage_is(input string req, input int s);
    logic [31:0] d;
    idle(3);
    rd_reg(3'd3, d);
    chk(req, 32'(d[5:4]), 32'(s));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(1_900_000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    idle(3);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd_reg(3'd3, d);
    chk("R1 status", d, 32'h1);
    rd_reg(3'd1, d);
    chk("R1 cfg", d, 32'h0);
    chk("R1 outputs", 32'({irq, cpu_rst, sys_rst, full_rst}), 32'h0);

    // R2 lock
    wr_reg(3'd1, mk_cfg(1, 0, 0, 0, 0, 1, 1, 1, 1));
    rd_reg(3'd1, d);
    chk("R2 locked cfg write", d, 32'h0);
    wr_reg(3'd0, KEY ^ 32'h1);
    wr_reg(3'd4, 32'd9);
    rd_reg(3'd4, d);
    chk("R2 wrong key tmo", d, 32'h0);
    rd_reg(3'd3, d);
    chk("R2 wrong key status", 32'(d[0]), 32'h1);
    wr_reg(3'd0, KEY);
    rd_reg(3'd3, d);
    chk("R2 unlocked status", 32'(d[0]), 32'h0);
    wr_reg(3'd4, 32'd3);
    rd_reg(3'd4, d);
    chk("R2 unlocked tmo", d, 32'd3);
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd4, 32'd7);
    rd_reg(3'd4, d);
    chk("R2 relocked tmo", d, 32'd3);
    wr_reg(3'd0, KEY);

    // R8 not running holds
    ticks(5);
    stage_is("R8 idle stage", 0);
    // R8 boot enable alone runs
    wr_reg(3'd1, mk_cfg(0, 0, 1, 0, 0, 0, 0, 0, 0));
    rd_reg(3'd3, d);
    chk("R8 running bit", 32'(d[1]), 32'h1);
    ticks(3);
    stage_is("R8 boot run", 1);

    // R9 disable
    wr_reg(3'd1, mk_cfg(1, 1, 1, 3'd5, 3'd6, 1, 2, 3, 4));
    wr_reg(3'd2, 32'h1);
    rd_reg(3'd1, d);
    chk("R9 disable cfg", d, mk_cfg(0, 1, 0, 3'd5, 3'd6, 0, 0, 0, 0));
    stage_is("R9 stage back 0", 0);

    // R7 feed restarts count
    wr_reg(3'd4, 32'd4);
    wr_reg(3'd5, 32'd50);
    wr_reg(3'd1, mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0));
    ticks(3);
    wr_reg(3'd2, 32'h8000_0000);
    ticks(3);
    stage_is("R7 count restarted", 0);
    ticks(1);
    stage_is("R7 expiry after feed", 1);
    wr_reg(3'd2, 32'h8000_0000);
    stage_is("R7 feed to stage 0", 0);
    rd_reg(3'd2, d);
    chk("R7 ctrl reads zero", d, 32'h0);

    // R11 no tick no progress
    wr_reg(3'd4, 32'd1);
    idle(60);
    stage_is("R11 no tick", 0);

    // R10 pause
    wr_reg(3'd4, 32'd3);
    wr_reg(3'd1, mk_cfg(1, 1, 0, 0, 0, 0, 0, 0, 0));
    sleep = 1'b1;
    ticks(6);
    stage_is("R10 paused", 0);
    sleep = 1'b0;
    ticks(3);
    stage_is("R10 resumed", 1);
    wr_reg(3'd2, 32'h1);
    wr_reg(3'd1, mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0));
    sleep = 1'b1;
    ticks(3);
    stage_is("R10 sleep without pause", 1);
    sleep = 1'b0;

    // R5 irq level and clear, timeout 0 acts as 1 (R3)
    wr_reg(3'd2, 32'h1);
    wr_reg(3'd4, 32'd0);
    wr_reg(3'd1, mk_cfg(1, 0, 0, 0, 0, 1, 0, 0, 0));
    ticks(1);
    idle(20);
    chk("R5 irq set", 32'(irq), 32'h1);
    stage_is("R3 zero timeout", 1);
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd3, 32'h4);
    idle(2);
    chk("R2 locked irq clear", 32'(irq), 32'h1);
    wr_reg(3'd0, KEY);
    wr_reg(3'd3, 32'h4);
    idle(2);
    chk("R5 irq cleared", 32'(irq), 32'h0);

    // Random trials: R3 R4 R5 R6
    for (int t = 0; t < 24; t++) begin
      logic [2:0] acts[4];
      int tm[4];
      logic [2:0] cl, sl;
      wr_reg(3'd2, 32'h1);
      wr_reg(3'd3, 32'h4);
      for (int s = 0; s < 4; s++) begin
        tm[s] = 1 + int'($urandom % 5);
        acts[s] = 3'($urandom % 8);
        wr_reg(3'(4 + s), 32'(tm[s]));
      end
      cl = 3'($urandom % 8);
      sl = 3'($urandom % 8);
      if (t == 0) begin cl = 3'd7; sl = 3'd0; acts = '{2, 3, 4, 5}; end
      wr_reg(3'd1, mk_cfg(1, 0, 0, cl, sl, acts[0], acts[1], acts[2], acts[3]));
      for (int s = 0; s < 4; s++) begin
        int base[3];
        base = n_p;
        ticks(tm[s] - 1);
        stage_is("R3 before expiry", s);
        ticks(1);
        idle(270);
        stage_is("R3 after expiry", (s < 3) ? s + 1 : 3);
        chk("R5 irq on action", 32'(irq), 32'(acts[s] == 3'd1));
        for (int k = 0; k < 3; k++) begin
          logic fired;
          fired = (acts[s] == 3'(2 + k));
          chk("R4 pulse count", 32'(n_p[k]), 32'(base[k] + int'(fired)));
          if (fired) chk("R6 pulse width", 32'(last_w[k]), 32'(exp_len(k == 0 ? cl : sl)));
        end
        if (irq) wr_reg(3'd3, 32'h4);
      end
      begin
        int base[3];
        base = n_p;
        ticks(3);
        idle(270);
        stage_is("R3 stage 3 hold", 3);
        chk("R3 no refire", 32'(n_p[0] + n_p[1] + n_p[2]),
            32'(base[0] + base[1] + base[2]));
        chk("R3 no refire irq", 32'(irq), 32'h0);
      end
    end
    finish_run();
  end
endmodule